// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether an incoming frame should be kept by looking at its 48-bit destination address. It answers with one registered verdict per request: keep or drop, plus a note saying whether the frame was taken as a broadcast or as a multicast. Four tests are applied in a fixed order, and the first one that fires decides the verdict.

The first test keeps any unicast address when promiscuous mode is on. The second keeps any group address when the accept-all-multicast control is on. The third keeps the all-ones address when the accept-broadcast control is on. The last test compares the address against a table of sixteen station addresses and keeps it if an enabled entry matches.

The host fills the table one entry at a time, giving the entry number and three 16-bit words. It then writes a 16-bit mask that selects which entries take part in matching. A one-cycle done pulse follows each mask write. While the surrounding controller is held in reset mode, the host can read back any entry through three read words.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, res_valid, accept, bcast_flag, mcast_flag and load_done are 0, every table entry is 0 and the enable mask is 0.
- R2: With promisc set and the group bit clear (dst_addr[0] = 0), the address is accepted with both flags 0, whatever the table holds.
- R3: If R2 does not apply, all_mcast is set and dst_addr[0] = 1, the address is accepted with mcast_flag = 1 and bcast_flag = 0. This also covers the all-ones address.
- R4: If R2 and R3 do not apply, accept_bcast is set and dst_addr is all ones, the address is accepted with bcast_flag = 1 and mcast_flag = 0.
- R5: If no earlier rule applies, the address is accepted with both flags 0 when it equals an entry whose mask bit is 1. Entries with a mask bit of 0 are ignored. With no match, accept is 0.
- R6: A table entry is written from three words. Word k supplies byte 2k in bits [7:0] and byte 2k+1 in bits [15:8]. Byte k of the address sits in dst_addr[8k+7:8k], and byte 0 carries the group bit.
- R7: res_valid is 1 exactly in the cycle after a cycle with req_valid = 1. accept and both flags are 0 whenever res_valid is 0.
- R8: A mask write (mask_wr_en = 1) replaces the whole enable mask and raises load_done for exactly the following cycle.
- R9: While reset_mode = 1, rd_word0, rd_word1 and rd_word2 return the three words of the entry selected by rd_ptr[3:0], in the word layout of R6. While reset_mode = 0, they read 0.
- R10: A request in the same cycle as a table write or mask write is decided on the contents that were there before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_wr_en | input | 1 | Write one table entry |
| cam_wr_idx | input | 4 | Entry number to write |
| cam_wr_w0 | input | 16 | Address bytes 1:0 |
| cam_wr_w1 | input | 16 | Address bytes 3:2 |
| cam_wr_w2 | input | 16 | Address bytes 5:4 |
| mask_wr_en | input | 1 | Load the enable mask |
| mask_wr_data | input | 16 | New enable mask, bit i for entry i |
| reset_mode | input | 1 | Controller reset mode; gates readback |
| rd_ptr | input | 16 | Readback entry pointer, low 4 bits used |
| rd_word0 | output | 16 | Readback word 0 |
| rd_word1 | output | 16 | Readback word 1 |
| rd_word2 | output | 16 | Readback word 2 |
| req_valid | input | 1 | Address presented for a decision |
| dst_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| promisc | input | 1 | Promiscuous mode |
| all_mcast | input | 1 | Accept all group addresses |
| accept_bcast | input | 1 | Accept the broadcast address |
| res_valid | output | 1 | Verdict valid |
| accept | output | 1 | Frame kept |
| bcast_flag | output | 1 | Kept as broadcast |
| mcast_flag | output | 1 | Kept as multicast |
| load_done | output | 1 | One-cycle pulse after a mask load |

## Verification
Several kinds of address are presented under different control settings: unicast addresses inside and outside the table, group addresses, and the all-ones address. Each pairing with the controls shows a different step of the priority. For example, the all-ones address with both group controls on separates multicast-before-broadcast ordering from the reverse. A table address whose mask bit is off is kept apart from one that is enabled, so that a match ignoring the mask is caught. Asymmetric byte patterns, read back with reset_mode both high and low, expose any swapped bytes or words and any missing read gate. A write in the same cycle as a request tells old-contents matching apart from new-contents matching.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int MAC_BYTES = 6;
  localparam int MAC_W     = 8 * MAC_BYTES;
  localparam int WORD_W    = 16;
  localparam int N_WORDS   = MAC_W / WORD_W;

  typedef logic [MAC_W-1:0]  mac_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic keep;
    logic bcast;
    logic mcast;
  } verdict_t;

  // Word k carries byte 2k low and byte 2k+1 high; byte k sits at [8k+7:8k].
  function automatic mac_t join_words(input word_t w0, input word_t w1, input word_t w2);
    return {w2, w1, w0};
  endfunction

  function automatic word_t pick_word(input mac_t m, input int k);
    return m[k*WORD_W +: WORD_W];
  endfunction

  function automatic logic group_bit(input mac_t m);
    return m[0];
  endfunction

  function automatic logic all_ones(input mac_t m);
    return &m;
  endfunction
endpackage

// File: rtl/daf_cam_store.sv
module daf_cam_store
  import daf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_w0,
  input  word_t            wr_w1,
  input  word_t            wr_w2,
  input  logic             mask_en,
  input  logic [DEPTH-1:0] mask_data,
  input  logic [IDX_W-1:0] rd_idx,
  output mac_t             entries [DEPTH],
  output logic [DEPTH-1:0] mask_q,
  output mac_t             rd_entry,
  output logic             mask_loaded
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  entries[i] <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))       entries[i] <= join_words(wr_w0, wr_w1, wr_w2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q      <= '0;
      mask_loaded <= 1'b0;
    end else begin
      mask_loaded <= mask_en;
      if (mask_en) mask_q <= mask_data;
    end
  end

  assign rd_entry = entries[rd_idx];
endmodule

// File: rtl/daf_cam_match.sv
module daf_cam_match
  import daf_pkg::*;
#(
  parameter int DEPTH = 16
)(
  input  mac_t             entries [DEPTH],
  input  logic [DEPTH-1:0] mask_q,
  input  mac_t             addr,
  output logic             hit
);
  logic [DEPTH-1:0] hit_vec;
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = mask_q[i] && (entries[i] == addr);
  end
  assign hit = |hit_vec;
endmodule

// File: rtl/daf_decide.sv
module daf_decide
  import daf_pkg::*;
(
  input  mac_t     addr,
  input  logic     promisc,
  input  logic     all_mcast,
  input  logic     accept_bcast,
  input  logic     cam_hit,
  output verdict_t verdict
);
  logic is_grp, is_bc;
  assign is_grp = group_bit(addr);
  assign is_bc  = all_ones(addr);

  always_comb begin
    verdict = '0;
    if (promisc && !is_grp)            verdict.keep = 1'b1;
    else if (all_mcast && is_grp)      verdict = '{keep: 1'b1, bcast: 1'b0, mcast: 1'b1};
    else if (accept_bcast && is_bc)    verdict = '{keep: 1'b1, bcast: 1'b1, mcast: 1'b0};
    else if (cam_hit)                  verdict.keep = 1'b1;
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import daf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PTR_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cam_wr_en,
  input  logic [IDX_W-1:0] cam_wr_idx,
  input  logic [15:0]      cam_wr_w0,
  input  logic [15:0]      cam_wr_w1,
  input  logic [15:0]      cam_wr_w2,
  input  logic             mask_wr_en,
  input  logic [DEPTH-1:0] mask_wr_data,
  input  logic             reset_mode,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [15:0]      rd_word0,
  output logic [15:0]      rd_word1,
  output logic [15:0]      rd_word2,
  input  logic             req_valid,
  input  logic [47:0]      dst_addr,
  input  logic             promisc,
  input  logic             all_mcast,
  input  logic             accept_bcast,
  output logic             res_valid,
  output logic             accept,
  output logic             bcast_flag,
  output logic             mcast_flag,
  output logic             load_done
);
  mac_t             entries [DEPTH];
  logic [DEPTH-1:0] mask_q;
  mac_t             rd_entry;
  logic             cam_hit;
  verdict_t         verdict;

  daf_cam_store #(.DEPTH(DEPTH)) u_store (
    .clk, .rst_n,
    .wr_en(cam_wr_en), .wr_idx(cam_wr_idx),
    .wr_w0(cam_wr_w0), .wr_w1(cam_wr_w1), .wr_w2(cam_wr_w2),
    .mask_en(mask_wr_en), .mask_data(mask_wr_data),
    .rd_idx(rd_ptr[IDX_W-1:0]),
    .entries, .mask_q, .rd_entry, .mask_loaded(load_done)
  );

  daf_cam_match #(.DEPTH(DEPTH)) u_match (
    .entries, .mask_q, .addr(dst_addr), .hit(cam_hit)
  );

  daf_decide u_decide (
    .addr(dst_addr), .promisc, .all_mcast, .accept_bcast,
    .cam_hit, .verdict
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      accept     <= 1'b0;
      bcast_flag <= 1'b0;
      mcast_flag <= 1'b0;
    end else begin
      res_valid  <= req_valid;
      accept     <= req_valid && verdict.keep;
      bcast_flag <= req_valid && verdict.bcast;
      mcast_flag <= req_valid && verdict.mcast;
    end
  end

  assign rd_word0 = reset_mode ? pick_word(rd_entry, 0) : '0;
  assign rd_word1 = reset_mode ? pick_word(rd_entry, 1) : '0;
  assign rd_word2 = reset_mode ? pick_word(rd_entry, 2) : '0;
endmodule

// File: rtl/daf_chk.sv
module daf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mask_wr_en,
  input logic        reset_mode,
  input logic [15:0] rd_word0,
  input logic [15:0] rd_word1,
  input logic [15:0] rd_word2,
  input logic        req_valid,
  input logic [47:0] dst_addr,
  input logic        promisc,
  input logic        all_mcast,
  input logic        res_valid,
  input logic        accept,
  input logic        bcast_flag,
  input logic        mcast_flag,
  input logic        load_done
);
  // R7
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  // R7
  res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !accept && !bcast_flag && !mcast_flag));
  // R3
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bcast_flag && mcast_flag) && ((bcast_flag || mcast_flag) -> accept));
  // R2
  promisc_unicast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && promisc && !dst_addr[0]) |=> (accept && !bcast_flag && !mcast_flag));
  // R3
  all_mcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !promisc && all_mcast && dst_addr[0]) |=> (accept && mcast_flag));
  // R8
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> load_done);
  // R8
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_en |=> !load_done);
  // R9
  rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reset_mode |-> (rd_word0 == 16'h0 && rd_word1 == 16'h0 && rd_word2 == 16'h0));
endmodule

bind dst_addr_filter daf_chk u_chk (
  .clk, .rst_n, .mask_wr_en, .reset_mode, .rd_word0, .rd_word1, .rd_word2,
  .req_valid, .dst_addr, .promisc, .all_mcast, .res_valid, .accept,
  .bcast_flag, .mcast_flag, .load_done
);

// File: tb/dst_addr_filter_tb.sv
module dst_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cam_wr_en = 1'b0;
  logic [3:0]  cam_wr_idx = '0;
  logic [15:0] cam_wr_w0 = '0, cam_wr_w1 = '0, cam_wr_w2 = '0;
  logic        mask_wr_en = 1'b0;
  logic [15:0] mask_wr_data = '0;
  logic        reset_mode = 1'b1;
  logic [15:0] rd_ptr = '0;
  logic [15:0] rd_word0, rd_word1, rd_word2;
  logic        req_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        promisc = 1'b0, all_mcast = 1'b0, accept_bcast = 1'b0;
  logic        res_valid, accept, bcast_flag, mcast_flag, load_done;

  int checks = 0;
  int bad = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  dst_addr_filter u_dut (.*);

  // Behavioural reference: byte lists per entry, enable list.
  byte unsigned ref_bytes [16][6];
  bit           ref_en [16];
  bit exp_valid, exp_acc, exp_bc, exp_mc, exp_ld;

  function automatic bit addr_in_table(input logic [47:0] a);
    for (int e = 0; e < 16; e++) begin
      bit same = ref_en[e];
      for (int b = 0; b < 6; b++)
        if (ref_bytes[e][b] != a[8*b +: 8]) same = 0;
      if (same) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < 16; e++) begin
        ref_en[e] = 0;
        for (int b = 0; b < 6; b++) ref_bytes[e][b] = 0;
      end
      {exp_valid, exp_acc, exp_bc, exp_mc, exp_ld} = '0;
    end else begin
      bit grp, ones;
      grp  = dst_addr[0];
      ones = (dst_addr == {48{1'b1}});
      exp_valid = req_valid;
      exp_acc = 0; exp_bc = 0; exp_mc = 0;
      if (req_valid) begin
        if (promisc && !grp) exp_acc = 1;
        else if (all_mcast && grp) begin exp_acc = 1; exp_mc = 1; end
        else if (accept_bcast && ones) begin exp_acc = 1; exp_bc = 1; end
        else exp_acc = addr_in_table(dst_addr);
      end
      exp_ld = mask_wr_en;
      if (cam_wr_en) begin
        ref_bytes[cam_wr_idx][0] = cam_wr_w0[7:0];
        ref_bytes[cam_wr_idx][1] = cam_wr_w0[15:8];
        ref_bytes[cam_wr_idx][2] = cam_wr_w1[7:0];
        ref_bytes[cam_wr_idx][3] = cam_wr_w1[15:8];
        ref_bytes[cam_wr_idx][4] = cam_wr_w2[7:0];
        ref_bytes[cam_wr_idx][5] = cam_wr_w2[15:8];
      end
      if (mask_wr_en)
        for (int e = 0; e < 16; e++) ref_en[e] = mask_wr_data[e];
    end
  end

  task automatic cmp(input string what, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, well after inputs settle and before the next edge.
  always @(negedge clk) begin
    #3;
    begin
      int p;
      logic [15:0] e0, e1, e2;
      p = rd_ptr[3:0];
      e0 = reset_mode ? {ref_bytes[p][1], ref_bytes[p][0]} : 16'h0;
      e1 = reset_mode ? {ref_bytes[p][3], ref_bytes[p][2]} : 16'h0;
      e2 = reset_mode ? {ref_bytes[p][5], ref_bytes[p][4]} : 16'h0;
      cmp("res_valid", 48'(res_valid), 48'(exp_valid));
      cmp("accept", 48'(accept), 48'(exp_acc));
      cmp("bcast_flag", 48'(bcast_flag), 48'(exp_bc));
      cmp("mcast_flag", 48'(mcast_flag), 48'(exp_mc));
      cmp("load_done", 48'(load_done), 48'(exp_ld));
      cmp("rd_words", {rd_word2, rd_word1, rd_word0}, {e2, e1, e0});
    end
  end

  task automatic idle();
    cam_wr_en = 0; mask_wr_en = 0; req_valid = 0;
  endtask

  task automatic put_entry(input int idx, input logic [47:0] a);
    @(negedge clk);
    idle();
    cam_wr_en = 1; cam_wr_idx = 4'(idx);
    cam_wr_w0 = a[15:0]; cam_wr_w1 = a[31:16]; cam_wr_w2 = a[47:32];
  endtask

  task automatic put_mask(input logic [15:0] m);
    @(negedge clk);
    idle();
    mask_wr_en = 1; mask_wr_data = m;
  endtask

  task automatic ask(input logic [47:0] a, input bit pr, input bit am, input bit ab);
    @(negedge clk);
    idle();
    req_valid = 1; dst_addr = a; promisc = pr; all_mcast = am; accept_bcast = ab;
  endtask

  task automatic gap();
    @(negedge clk);
    idle();
  endtask

  localparam logic [47:0] A0 = 48'hA1B2_C3D4_E5F6;
  localparam logic [47:0] A1 = 48'h0102_0304_0506;
  localparam logic [47:0] A2 = 48'h7788_99AA_BC0E;
  localparam logic [47:0] AF = 48'h1357_9BDF_2468;
  localparam logic [47:0] UX = 48'h4242_4242_4240;
  localparam logic [47:0] MC = 48'h0000_5E00_0001;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rd_ptr = 16'h0005;
    @(negedge clk);
    rst_n = 1;
    gap(); gap();

    cur_req = "R6";
    put_entry(0, A0);
    put_entry(1, A1);
    put_entry(2, A2);
    put_entry(15, AF);
    put_entry(7, BC);
    gap();

    cur_req = "R8";
    put_mask(16'h8005);
    gap();
    put_mask(16'h8005);
    put_mask(16'h8005);
    gap();

    cur_req = "R9";
    reset_mode = 1; rd_ptr = 16'h0012; gap();
    rd_ptr = 16'hFFFF; gap();
    rd_ptr = 16'h0001; gap();
    reset_mode = 0; gap();
    rd_ptr = 16'h0000; gap();
    reset_mode = 1; gap();

    cur_req = "R5";
    ask(A0, 0, 0, 0);
    ask(A1, 0, 0, 0);
    ask(UX, 0, 0, 0);
    ask(AF, 0, 0, 0);
    ask(A2, 0, 0, 0);
    ask(A0 ^ 48'h0100_0000_0000, 0, 0, 0);
    gap();

    cur_req = "R2";
    ask(UX, 1, 0, 0);
    ask(A1, 1, 0, 0);
    ask(MC, 1, 0, 0);
    ask(UX, 1, 1, 1);
    gap();

    cur_req = "R3";
    ask(MC, 0, 1, 0);
    ask(BC, 0, 1, 1);
    ask(BC, 1, 1, 0);
    ask(UX, 0, 1, 0);
    gap();

    cur_req = "R4";
    ask(BC, 0, 0, 1);
    ask(BC, 0, 0, 0);
    ask(MC, 0, 0, 1);
    put_mask(16'h8085);
    ask(BC, 0, 0, 0);
    gap();

    cur_req = "R7";
    gap(); gap();
    ask(A0, 0, 0, 0);
    gap();
    ask(UX, 0, 0, 0);
    ask(A2, 0, 0, 0);
    gap(); gap();

    cur_req = "R10";
    @(negedge clk);
    idle();
    req_valid = 1; dst_addr = A0; promisc = 0; all_mcast = 0; accept_bcast = 0;
    cam_wr_en = 1; cam_wr_idx = 0;
    cam_wr_w0 = UX[15:0]; cam_wr_w1 = UX[31:16]; cam_wr_w2 = UX[47:32];
    ask(A0, 0, 0, 0);
    ask(UX, 0, 0, 0);
    @(negedge clk);
    idle();
    req_valid = 1; dst_addr = A1;
    mask_wr_en = 1; mask_wr_data = 16'h0002;
    ask(A1, 0, 0, 0);
    ask(UX, 0, 0, 0);
    gap(); gap();

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule